// File: doc/BRIEF.md
# Dual-Converter Pipelined Read Sequencer

This block lives in the host logic and keeps a parallel-output, dual simultaneous-sampling converter running without pause. It divides the system clock down to make the converter's conversion clock, drives the conversion-start strobe, the pair-select line, the chip select and the read strobe, and captures the 12-bit data bus. Each conversion converts one input pair on both converters at once. The block alternates between pair 0 and pair 1 on successive conversions.

Every frame starts one conversion. During that conversion the block reads the two results of the conversion before it, converter A first and then converter B. Each captured word leaves on a valid/ready stream, tagged with its converter and pair. All timing limits are parameters counted in system clock cycles. The block keeps reads out of a window around each conversion start. It also keeps the read strobe inside a held chip select, so the converter's internal A/B read pointer never falls out of step with the host.

Top module: `adc_pair_sequencer`

## Requirements
- R1: `adc_clk` is a square wave with a period of `CLK_DIV` system cycles, low for the first half and high for the second half.
- R2: `adc_convst_n` falls once every `CLK_DIV*(CONV_CLKS+GAP_CLKS)` system cycles and stays low for exactly `CVST_LOW_CYC` cycles. Every fall happens while `adc_clk` is low.
- R3: `adc_a0` alternates between conversion starts, so the pairs run 0, 1, 0, 1. It holds still while `adc_convst_n` is low and until the first `adc_clk` rise after it. Before each conversion start it has been stable for at least `A0_SETUP_CYC` cycles.
- R4: Each read holds `adc_cs_n` low across exactly two `adc_rd_n` low pulses. Each pulse lasts `RD_LOW_CYC` cycles, and the pulses are separated by `RD_HIGH_CYC` high cycles. `adc_rd_n` is never low while `adc_cs_n` is high.
- R5: `adc_cs_n` and `adc_rd_n` stay high from `KEEP_PRE_CYC` cycles before each conversion start until `KEEP_POST_CYC` cycles after it.
- R6: The word on the bus in the last cycle of the first read pulse is emitted as converter A, and the word in the last cycle of the second pulse as converter B. `out_tag` is {pair, converter} with converter A=0 and B=1, so 0=A pair 0, 1=B pair 0, 2=A pair 1, 3=B pair 1.
- R7: The reads of each frame return the results of the previous conversion, and `adc_a0` carries that conversion's pair during the reads. Results therefore stream as tags 0,1,2,3,0,... in conversion order.
- R8: The reads of the first frame after reset are performed but discarded. The first emitted result is converter A of the first conversion after reset.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_tag` and `out_data` hold unchanged.
- R10: A new result that arrives while an unaccepted result is held is dropped, and `overflow` is set. `overflow` stays set until reset.
- R11: While `rst` is high, `adc_convst_n`, `adc_cs_n` and `adc_rd_n` are high, `out_valid` is low and `overflow` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_clk | output | 1 | Conversion clock to the converter |
| adc_convst_n | output | 1 | Conversion start, active low |
| adc_a0 | output | 1 | Pair select for conversion and read |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_data_in | input | 12 | Converter data bus |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| out_tag | output | 2 | {pair, converter} of the result |
| out_data | output | 12 | Two's-complement result word |
| overflow | output | 1 | Sticky: a result was dropped |

## Verification
The bench models the converter as a bus whose A/B read pointer resets on each conversion start and advances on every read pulse, whether or not chip select is low. Every stored word encodes its conversion number, pair and converter. A wrong pairing, a stale frame, a swapped A/B order or a kept dummy read therefore each show up as a distinct data mismatch. The stream is drained with acceptance delays of zero, one and two cycles to exercise the hold path. A long stall then forces a drop and shows which word survives. A reset in the middle of a run shows that the dummy-read discard happens again. Pin monitors measure clock period, strobe widths, address setup and the keep-out window on every frame.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int SMP_W = 12;

    typedef enum logic [1:0] {
        TAG_A_P0 = 2'd0,
        TAG_B_P0 = 2'd1,
        TAG_A_P1 = 2'd2,
        TAG_B_P1 = 2'd3
    } chan_tag_e;

    typedef struct packed {
        chan_tag_e        tag;
        logic [SMP_W-1:0] data;
    } smp_t;

    typedef struct packed {
        logic convst_n;
        logic cs_n;
        logic rd_n;
        logic strb_a;
        logic strb_b;
    } drive_t;

    localparam drive_t DRV_IDLE = '{convst_n: 1'b1, cs_n: 1'b1, rd_n: 1'b1,
                                    strb_a: 1'b0, strb_b: 1'b0};

    function automatic chan_tag_e tag_of(input logic pair, input logic side);
        return chan_tag_e'({pair, side});
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic adc_clk
);
    localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            adc_clk <= 1'b0;
        end else begin
            cnt     <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
            adc_clk <= (cnt >= CW'(HALF));
        end
    end

endmodule

// File: rtl/adc_frame_timer.sv
module adc_frame_timer
    import adc_seq_pkg::*;
#(
    parameter int FRAME_CYC     = 136,
    parameter int CVST_LOW_CYC  = 2,
    parameter int A0_FLIP_CYC   = 8,
    parameter int RD_START_CYC  = 9,
    parameter int RD_LOW_CYC    = 2,
    parameter int RD_HIGH_CYC   = 2,
    parameter int A0_SETUP_CYC  = 13,
    parameter int KEEP_PRE_CYC  = 7,
    parameter int KEEP_POST_CYC = 1
) (
    input  logic   clk,
    input  logic   rst,
    output drive_t drv,
    output logic   a0,
    output logic   primed
);
    localparam int TW     = $clog2(FRAME_CYC);
    localparam int P1_BEG = RD_START_CYC + 1;
    localparam int P1_END = RD_START_CYC + RD_LOW_CYC;
    localparam int P2_BEG = P1_END + RD_HIGH_CYC + 1;
    localparam int P2_END = P2_BEG + RD_LOW_CYC - 1;
    localparam int CS_END = P2_END + 1;
    localparam int AW     = $clog2(A0_SETUP_CYC + 1);

    typedef logic [TW-1:0] tick_t;

    tick_t          t;
    drive_t         nxt;
    logic [AW-1:0]  a0_age;

    function automatic logic in_span(input tick_t v, input int lo, input int hi);
        return (int'(v) >= lo) && (int'(v) <= hi);
    endfunction

    // Decode of the frame position; all pins leave through flops below.
    always_comb begin
        nxt.convst_n = !in_span(t, 0, CVST_LOW_CYC - 1);
        nxt.cs_n     = !in_span(t, RD_START_CYC, CS_END);
        nxt.rd_n     = !(in_span(t, P1_BEG, P1_END) || in_span(t, P2_BEG, P2_END));
        nxt.strb_a   = in_span(t, P1_END, P1_END);
        nxt.strb_b   = in_span(t, P2_END, P2_END);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t      <= '0;
            drv    <= DRV_IDLE;
            a0     <= 1'b0;
            primed <= 1'b0;
            a0_age <= '0;
        end else begin
            t   <= (int'(t) == FRAME_CYC - 1) ? '0 : t + 1'b1;
            drv <= nxt;
            if (int'(t) == A0_FLIP_CYC) begin
                a0     <= ~a0;
                a0_age <= '0;
            end else if (int'(a0_age) < A0_SETUP_CYC) begin
                a0_age <= a0_age + 1'b1;
            end
            if (int'(t) == FRAME_CYC - 1)
                primed <= 1'b1;
        end
    end

    AST_RD_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        !drv.rd_n |-> !drv.cs_n) else $error("read strobe outside chip select"); // R4
    AST_CONVST_NO_READ: assert property (@(posedge clk) disable iff (rst)
        !drv.convst_n |-> (drv.cs_n && drv.rd_n)) else $error("read during start"); // R5
    AST_KEEPOUT_PRE: assert property (@(posedge clk) disable iff (rst)
        ((int'(t) > FRAME_CYC - KEEP_PRE_CYC) || (t == '0)) |-> (drv.cs_n && drv.rd_n))
        else $error("read inside pre-start window"); // R5
    AST_KEEPOUT_POST: assert property (@(posedge clk) disable iff (rst)
        ((int'(t) >= 1) && (int'(t) <= KEEP_POST_CYC + 1)) |-> (drv.cs_n && drv.rd_n))
        else $error("read inside post-start window"); // R5
    AST_A0_SETUP: assert property (@(posedge clk) disable iff (rst)
        (primed && $fell(drv.convst_n)) |-> (int'(a0_age) >= A0_SETUP_CYC))
        else $error("pair select setup too short"); // R3
    AST_A0_HELD_CONV: assert property (@(posedge clk) disable iff (rst)
        !drv.convst_n |-> $stable(a0)) else $error("pair select moved during start"); // R3
    AST_STRB_IN_RD: assert property (@(posedge clk) disable iff (rst)
        (drv.strb_a || drv.strb_b) |-> !drv.rd_n) else $error("capture outside read"); // R6

endmodule

// File: rtl/adc_result_out.sv
module adc_result_out
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_vld,
    input  smp_t in_smp,
    input  logic ready,
    output logic out_valid,
    output smp_t out_smp,
    output logic overflow
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_smp   <= '0;
            overflow  <= 1'b0;
        end else if (in_vld) begin
            if (!out_valid || ready) begin
                out_valid <= 1'b1;
                out_smp   <= in_smp;
            end else begin
                overflow  <= 1'b1;
            end
        end else if (out_valid && ready) begin
            out_valid <= 1'b0;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !ready) |=> (out_valid && $stable(out_smp)))
        else $error("held result changed"); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow) else $error("overflow cleared"); // R10
    AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        (in_vld && out_valid && !ready) |=> overflow) else $error("drop not flagged"); // R10

endmodule

// File: rtl/adc_pair_sequencer.sv
module adc_pair_sequencer
    import adc_seq_pkg::*;
#(
    parameter int CLK_DIV       = 8,
    parameter int CONV_CLKS     = 16,
    parameter int GAP_CLKS      = 1,
    parameter int CVST_LOW_CYC  = 2,
    parameter int RD_LOW_CYC    = 2,
    parameter int RD_HIGH_CYC   = 2,
    parameter int A0_SETUP_CYC  = 13,
    parameter int KEEP_PRE_CYC  = 7,
    parameter int KEEP_POST_CYC = 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic             adc_clk,
    output logic             adc_convst_n,
    output logic             adc_a0,
    output logic             adc_cs_n,
    output logic             adc_rd_n,
    input  logic [SMP_W-1:0] adc_data_in,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [1:0]       out_tag,
    output logic [SMP_W-1:0] out_data,
    output logic             overflow
);
    localparam int FRAME_CYC    = CLK_DIV * (CONV_CLKS + GAP_CLKS);
    // Pair select moves one full converter clock after the start, well past the latch edge.
    localparam int A0_FLIP_CYC  = CLK_DIV;
    localparam int RD_START_CYC = (A0_FLIP_CYC + 1 > KEEP_POST_CYC + 1) ?
                                  A0_FLIP_CYC + 1 : KEEP_POST_CYC + 1;

    drive_t drv;
    logic   a0;
    logic   primed;
    logic   cap_vld;
    smp_t   cap_smp;
    smp_t   out_smp;

    adc_clk_div #(.DIV(CLK_DIV)) clk_div_i (
        .clk     (clk),
        .rst     (rst),
        .adc_clk (adc_clk)
    );

    adc_frame_timer #(
        .FRAME_CYC     (FRAME_CYC),
        .CVST_LOW_CYC  (CVST_LOW_CYC),
        .A0_FLIP_CYC   (A0_FLIP_CYC),
        .RD_START_CYC  (RD_START_CYC),
        .RD_LOW_CYC    (RD_LOW_CYC),
        .RD_HIGH_CYC   (RD_HIGH_CYC),
        .A0_SETUP_CYC  (A0_SETUP_CYC),
        .KEEP_PRE_CYC  (KEEP_PRE_CYC),
        .KEEP_POST_CYC (KEEP_POST_CYC)
    ) timer_i (
        .clk    (clk),
        .rst    (rst),
        .drv    (drv),
        .a0     (a0),
        .primed (primed)
    );

    // Capture at the edge that closes each read pulse; first frame is discarded.
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_vld <= 1'b0;
            cap_smp <= '0;
        end else begin
            cap_vld <= primed && (drv.strb_a || drv.strb_b);
            if (drv.strb_a || drv.strb_b)
                cap_smp <= '{tag: tag_of(a0, drv.strb_b), data: adc_data_in};
        end
    end

    adc_result_out out_i (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (cap_vld),
        .in_smp    (cap_smp),
        .ready     (out_ready),
        .out_valid (out_valid),
        .out_smp   (out_smp),
        .overflow  (overflow)
    );

    assign adc_convst_n = drv.convst_n;
    assign adc_cs_n     = drv.cs_n;
    assign adc_rd_n     = drv.rd_n;
    assign adc_a0       = a0;
    assign out_tag      = out_smp.tag;
    assign out_data     = out_smp.data;

endmodule

// File: tb/adc_pair_sequencer_tb_top.sv
`timescale 1ns/1ps
module adc_pair_sequencer_tb_top;

    localparam int CLK_DIV = 8;
    localparam int FRAME   = CLK_DIV * 17;
    localparam int CVL     = 2;
    localparam int RDL     = 2;
    localparam int RDH     = 2;
    localparam int A0S     = 13;
    localparam int PRE     = 7;
    localparam int POST    = 1;

    // {accept delay[3:2], expected tag[1:0]}
    localparam logic [3:0] VEC [8] = '{4'b00_00, 4'b01_01, 4'b10_10, 4'b00_11,
                                       4'b10_00, 4'b01_01, 4'b00_10, 4'b01_11};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adc_clk, adc_convst_n, adc_a0, adc_cs_n, adc_rd_n;
    logic [11:0] adc_data;
    logic        out_valid, out_ready, overflow;
    logic [1:0]  out_tag;
    logic [11:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    adc_pair_sequencer dut_i (
        .clk(clk), .rst(rst), .adc_clk(adc_clk), .adc_convst_n(adc_convst_n),
        .adc_a0(adc_a0), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
        .adc_data_in(adc_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_tag(out_tag), .out_data(out_data), .overflow(overflow)
    );

    function automatic logic [11:0] word(input int k, input logic pair, input logic side);
        logic [31:0] kk;
        kk = k;
        return {kk[7:0], 1'b1, pair, side, 1'b0};
    endfunction

    // ---------------- converter model ----------------
    logic [11:0] regs [4] = '{12'hBAD, 12'hBAD, 12'hBAD, 12'hBAD};
    int   fall_cnt  = 0;
    int   latch_cnt = 0;
    int   rd_cnt    = 0;
    int   rd_base   = 0;
    logic cur_pair  = 1'b0;
    logic a0_at_fall = 1'b0;
    int   v_latch   = 0;
    logic side;

    always @(negedge adc_convst_n) begin
        if (fall_cnt != 0) begin
            regs[{cur_pair, 1'b0}] <= word(fall_cnt - 1, cur_pair, 1'b0);
            regs[{cur_pair, 1'b1}] <= word(fall_cnt - 1, cur_pair, 1'b1);
        end
        fall_cnt   <= fall_cnt + 1;
        rd_base    <= rd_cnt;
        a0_at_fall <= adc_a0;
    end

    always @(posedge adc_clk) begin
        if (fall_cnt != latch_cnt) begin
            latch_cnt <= fall_cnt;
            cur_pair  <= adc_a0;
            if (adc_a0 != a0_at_fall) v_latch <= v_latch + 1;
        end
    end

    always @(posedge adc_rd_n) rd_cnt <= rd_cnt + 1;

    always_comb begin
        side     = 1'(rd_cnt - rd_base);
        adc_data = (!adc_cs_n && !adc_rd_n) ? regs[{adc_a0, side}] : 12'hEEE;
    end

    // ---------------- pin monitors ----------------
    int v1 = 0, v2 = 0, v3 = 0, v4 = 0, v5 = 0;
    int n_rise = 0, n_fall = 0, n_reads = 0;
    int since_rise = 0, since_fall = 0, a0_age = 0, low_cv = 0, low_rd = 0, gap = 0, rd_in_cs = 0;
    bit have_rise = 0, have_fall = 0;
    logic p_clk = 0, p_conv = 1, p_cs = 1, p_rd = 1, p_a0 = 0, last_fall_a0 = 0;

    always @(negedge clk) begin
        if (rst) begin
            have_rise = 0; have_fall = 0; since_rise = 0; since_fall = 0;
            low_cv = 0; low_rd = 0; a0_age = 0; rd_in_cs = 0; gap = 0;
        end else begin
            since_rise++; since_fall++; a0_age++;
            if (adc_a0 != p_a0) a0_age = 0;
            if (adc_clk && !p_clk) begin
                if (have_rise && since_rise != CLK_DIV) v1++;
                n_rise++; since_rise = 0; have_rise = 1;
            end
            if (!adc_convst_n && p_conv) begin
                if (adc_clk) v2++;
                if (have_fall && since_fall != FRAME) v2++;
                if (have_fall && a0_age < A0S) v3++;
                if (have_fall && adc_a0 == last_fall_a0) v3++;
                last_fall_a0 = adc_a0; since_fall = 0; have_fall = 1; n_fall++;
            end
            if (!adc_convst_n) low_cv++;
            else if (!p_conv) begin
                if (low_cv != CVL) v2++;
                low_cv = 0;
            end
            if (!adc_rd_n) begin
                low_rd++;
                if (adc_cs_n) v4++;
                if (p_rd) begin
                    if (rd_in_cs == 1 && gap != RDH) v4++;
                    rd_in_cs++;
                end
            end else begin
                if (!p_rd) begin
                    if (low_rd != RDL) v4++;
                    low_rd = 0; gap = 1;
                end else gap++;
            end
            if (adc_cs_n && !p_cs) begin
                if (rd_in_cs != 2) v4++;
                rd_in_cs = 0; n_reads++;
            end
            if (have_fall && (!adc_cs_n || !adc_rd_n) &&
                (since_fall <= POST || since_fall >= FRAME - PRE)) v5++;
        end
        p_clk = adc_clk; p_conv = adc_convst_n; p_cs = adc_cs_n; p_rd = adc_rd_n; p_a0 = adc_a0;
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_valid(output bit seen, output int waited);
        seen = 0; waited = 0;
        for (int i = 0; i < 600 && !seen; i++) begin
            @(negedge clk);
            waited++;
            if (out_valid) seen = 1;
        end
    endtask

    function automatic logic [11:0] exp_word(input int base, input int j);
        return word(base + j / 2, 1'((j / 2) % 2), 1'(j % 2));
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit seen;
        int waited;
        int base;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(adc_convst_n && adc_cs_n && adc_rd_n, "R11 pins idle",
            {adc_convst_n, adc_cs_n, adc_rd_n}, 3'b111);
        chk(!out_valid && !overflow, "R11 stream idle", {out_valid, overflow}, 0);
        rst = 1'b0;

        // Table walk: tags, data and hold with short accept delays.
        for (int j = 0; j < 8; j++) begin
            wait_valid(seen, waited);
            if (j == 0) chk(seen && waited > FRAME, "R8 first result after dummy frame", waited, FRAME);
            chk(seen, "R7 result present", seen, 1);
            chk(out_tag == VEC[j][1:0], "R6 tag order", out_tag, VEC[j][1:0]);
            chk(out_data == exp_word(0, j), (j == 0) ? "R8 first word" : "R7 word of previous conversion",
                out_data, exp_word(0, j));
            for (int k = 0; k < int'(VEC[j][3:2]); k++) begin
                @(negedge clk);
                chk(out_valid && out_data == exp_word(0, j) && out_tag == VEC[j][1:0],
                    "R9 held while not ready", out_data, exp_word(0, j));
            end
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
        chk(!overflow, "R10 no drop under prompt draining", overflow, 0);

        // Long stall: converter B of the next pair is dropped.
        wait_valid(seen, waited);
        chk(seen && out_data == exp_word(0, 8), "R7 stalled word", out_data, exp_word(0, 8));
        repeat (10) @(negedge clk);
        chk(out_valid && out_data == exp_word(0, 8) && out_tag == 2'd0, "R9 held across arrival",
            out_data, exp_word(0, 8));
        chk(overflow, "R10 overflow set on drop", overflow, 1);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        wait_valid(seen, waited);
        chk(seen && out_data == exp_word(0, 10) && out_tag == 2'd2, "R10 dropped word not delivered",
            out_data, exp_word(0, 10));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(overflow, "R10 overflow sticky", overflow, 1);

        // Reset in mid-run: state clears and the dummy frame repeats.
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(adc_convst_n && adc_cs_n && adc_rd_n && !out_valid && !overflow, "R11 reset mid-run",
            {adc_convst_n, adc_cs_n, adc_rd_n, out_valid, overflow}, 5'b11100);
        base = fall_cnt;
        rst = 1'b0;
        out_ready = 1'b1;
        wait_valid(seen, waited);
        chk(seen && waited > FRAME, "R8 dummy frame after reset", waited, FRAME);
        chk(out_data == exp_word(base, 0) && out_tag == 2'd0, "R8 first word after reset",
            out_data, exp_word(base, 0));
        repeat (3 * FRAME) @(negedge clk);

        chk(v1 == 0 && n_rise > 20, "R1 clock period", v1, 0);
        chk(v2 == 0 && n_fall > 8, "R2 start strobe width, period, phase", v2, 0);
        chk(v3 == 0 && v_latch == 0, "R3 pair select setup and alternation", v3 + v_latch, 0);
        chk(v4 == 0 && n_reads > 8, "R4 read pulse shape", v4, 0);
        chk(v5 == 0, "R5 keep-out window", v5, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule